// File: doc/BRIEF.md
# Mode-Register Command Spacing Guard

This block sits in the command path of a DRAM controller, between the command scheduler and the registered command bus toward the memory device. Each command the scheduler offers is either passed on, or held back because it would arrive too soon after a mode-register-set (MRS) command. While a command is held, the bus carries deselect cycles.

Two windows open each time an MRS command is accepted. One gates the next MRS and is set by a programmable MRS-to-MRS cycle count. The other gates every command that is neither MRS nor deselect and is set by a programmable MRS-to-other cycle count. Some mode-register writes need their own timing. For those the scheduler raises an exception flag with the MRS and supplies an override count, which then sets both windows. Deselect never waits and never changes a window.

Top module: `mrs_spacing_guard`

## Requirements
- R1: After reset both windows are closed. The bus shows deselect (opcode 0), and the first offered command of any kind is accepted in the cycle it is offered.
- R2: The opcode encoding is 0 = deselect, 1 = MRS and 2..7 = other commands. A command accepted at a clock edge (`req_valid` and `req_ready` both high) appears on `dram_op` and `dram_mr` from that edge for exactly one cycle.
- R3: Let an MRS be accepted at edge k with spacing t. A later MRS is not accepted before edge k+t. If it is waiting, it is accepted exactly at edge k+t.
- R4: Let an MRS be accepted at edge k with other-command spacing m. A command with opcode 2..7 is not accepted before edge k+m. If it is waiting, it is accepted exactly at edge k+m.
- R5: A deselect request is always ready. Accepting a deselect changes neither window, so the wait of a later command is the same as if no deselect had been accepted.
- R6: When `req_excp` is high with an accepted MRS, `req_excp_cnt` replaces both the MRS-to-MRS and the MRS-to-other spacing for that MRS.
- R7: Each accepted MRS restarts both windows from its own edge, even while an earlier window is still open.
- R8: A spacing value of 0 or 1 imposes no wait. Commands may then be accepted at back-to-back edges.
- R9: While a command is held back, `req_ready` is low and the bus shows deselect. Held cycles never put a non-deselect opcode on `dram_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Scheduler offers a command |
| req_ready | output | 1 | Guard accepts the offered command this cycle |
| req_op | input | 3 | Offered opcode (0 deselect, 1 MRS, 2..7 other) |
| req_mr | input | MR_W (3) | Mode-register index carried with the command |
| req_excp | input | 1 | Offered MRS uses the override spacing |
| req_excp_cnt | input | CNT_W (8) | Override spacing in cycles |
| cfg_tmrd | input | CNT_W (8) | MRS-to-MRS spacing in cycles |
| cfg_tmod | input | CNT_W (8) | MRS-to-other spacing in cycles |
| dram_op | output | 3 | Opcode driven to the device |
| dram_mr | output | MR_W (3) | Mode-register index driven to the device |

## Verification
The gap assertions assume that the spacing inputs and the override count are read at the edge where an MRS is accepted. They also assume that the scheduler keeps an offered command steady until it is taken. The stimulus changes `cfg_tmrd` and `cfg_tmod` only when nothing is being offered. It holds each request, with its exception flag and override count, unchanged from the first offered cycle to acceptance. Opcodes stay within the 3-bit encoding given in R2.

// File: rtl/mrs_guard_pkg.sv
package mrs_guard_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_DES = 3'd0,
    OP_MRS = 3'd1,
    OP_ACT = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4,
    OP_PRE = 3'd5,
    OP_REF = 3'd6,
    OP_ZQC = 3'd7
  } dram_op_e;

  // deselect is never gated
  function automatic logic op_is_des(input logic [OP_W-1:0] op);
    return op == OP_DES;
  endfunction

  function automatic logic op_is_mrs(input logic [OP_W-1:0] op);
    return op == OP_MRS;
  endfunction

  // any real command other than a mode-register write
  function automatic logic op_is_other(input logic [OP_W-1:0] op);
    return !op_is_des(op) && !op_is_mrs(op);
  endfunction

endpackage

// File: rtl/mrs_window_cnt.sv
module mrs_window_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] span,
  output logic             win_open
);

  // A spacing of t cycles lets the next gated command go at edge k+t.
  // The counter is armed with t-1 and the window is open while non-zero.
  function automatic logic [CNT_W-1:0] arm_value(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (arm) begin
      cnt_q <= arm_value(span);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign win_open = (cnt_q != '0);

endmodule

// File: rtl/mrs_cmd_gate.sv
module mrs_cmd_gate
  import mrs_guard_pkg::*;
(
  input  logic            req_valid,
  input  logic [OP_W-1:0] req_op,
  input  logic            mrd_open,
  input  logic            mod_open,
  output logic            allow,
  output logic            blk_mrs,
  output logic            blk_other,
  output logic            take,
  output logic            take_mrs
);

  always_comb begin
    blk_mrs   = op_is_mrs(req_op) && mrd_open;
    blk_other = op_is_other(req_op) && mod_open;
    allow     = !(blk_mrs || blk_other);
    take      = req_valid && allow;
    take_mrs  = take && op_is_mrs(req_op);
  end

endmodule

// File: rtl/mrs_cmd_drive.sv
module mrs_cmd_drive
  import mrs_guard_pkg::*;
#(
  parameter int MR_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [OP_W-1:0] req_op,
  input  logic [MR_W-1:0] req_mr,
  output logic [OP_W-1:0] dram_op,
  output logic [MR_W-1:0] dram_mr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dram_op <= OP_DES;
      dram_mr <= '0;
    end else if (take) begin
      dram_op <= req_op;
      dram_mr <= req_mr;
    end else begin
      dram_op <= OP_DES;
      dram_mr <= '0;
    end
  end

endmodule

// File: rtl/mrs_spacing_guard.sv
module mrs_spacing_guard
  import mrs_guard_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int MR_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [MR_W-1:0]  req_mr,
  input  logic             req_excp,
  input  logic [CNT_W-1:0] req_excp_cnt,
  input  logic [CNT_W-1:0] cfg_tmrd,
  input  logic [CNT_W-1:0] cfg_tmod,
  output logic [2:0]       dram_op,
  output logic [MR_W-1:0]  dram_mr
);

  localparam int NWIN    = 2;
  localparam int WIN_MRD = 0;
  localparam int WIN_MOD = 1;

  // named internal events
  logic             allow;
  logic             blk_mrs;
  logic             blk_other;
  logic             take;
  logic             take_mrs;
  logic [NWIN-1:0]  win_open;
  logic [CNT_W-1:0] span [NWIN];

  // the override count replaces both spacings for a flagged MRS
  function automatic logic [CNT_W-1:0] pick_span(input logic excp,
                                                 input logic [CNT_W-1:0] ovr,
                                                 input logic [CNT_W-1:0] nominal);
    return excp ? ovr : nominal;
  endfunction

  assign span[WIN_MRD] = pick_span(req_excp, req_excp_cnt, cfg_tmrd);
  assign span[WIN_MOD] = pick_span(req_excp, req_excp_cnt, cfg_tmod);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    mrs_window_cnt #(.CNT_W(CNT_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (take_mrs),
      .span     (span[w]),
      .win_open (win_open[w])
    );
  end

  mrs_cmd_gate u_gate (
    .req_valid (req_valid),
    .req_op    (req_op),
    .mrd_open  (win_open[WIN_MRD]),
    .mod_open  (win_open[WIN_MOD]),
    .allow     (allow),
    .blk_mrs   (blk_mrs),
    .blk_other (blk_other),
    .take      (take),
    .take_mrs  (take_mrs)
  );

  assign req_ready = allow;

  mrs_cmd_drive #(.MR_W(MR_W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .req_op  (req_op),
    .req_mr  (req_mr),
    .dram_op (dram_op),
    .dram_mr (dram_mr)
  );

endmodule

// File: rtl/mrs_spacing_guard_chk.sv
module mrs_spacing_guard_chk #(
  parameter int CNT_W = 8,
  parameter int MR_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_op,
  input logic             req_excp,
  input logic [CNT_W-1:0] req_excp_cnt,
  input logic [CNT_W-1:0] cfg_tmrd,
  input logic [CNT_W-1:0] cfg_tmod,
  input logic [2:0]       dram_op,
  input logic             blk_mrs,
  input logic             blk_other
);

  localparam int GAP_W = CNT_W + 2;

  logic             acc;
  logic             acc_mrs;
  logic             acc_oth;
  logic             seen;
  logic [GAP_W-1:0] gap;
  logic [CNT_W-1:0] need_mrd;
  logic [CNT_W-1:0] need_mod;

  assign acc     = req_valid && req_ready;
  assign acc_mrs = acc && (req_op == 3'd1);
  assign acc_oth = acc && (req_op != 3'd1) && (req_op != 3'd0);

  // edges elapsed since the last accepted MRS, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      gap      <= '0;
      need_mrd <= '0;
      need_mod <= '0;
    end else if (acc_mrs) begin
      seen     <= 1'b1;
      gap      <= GAP_W'(1);
      need_mrd <= req_excp ? req_excp_cnt : cfg_tmrd;
      need_mod <= req_excp ? req_excp_cnt : cfg_tmod;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  assert_mrs_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mrs && seen) |-> (gap >= GAP_W'(need_mrd)));

  assert_other_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_oth && seen) |-> (gap >= GAP_W'(need_mod)));

  assert_des_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0) |-> req_ready);

  assert_issue_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (dram_op == $past(req_op)));

  assert_held_des_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (blk_mrs || blk_other)) |=> (dram_op == 3'd0));

  assert_idle_des_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (dram_op == 3'd0));

endmodule

bind mrs_spacing_guard mrs_spacing_guard_chk #(.CNT_W(CNT_W), .MR_W(MR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_op       (req_op),
  .req_excp     (req_excp),
  .req_excp_cnt (req_excp_cnt),
  .cfg_tmrd     (cfg_tmrd),
  .cfg_tmod     (cfg_tmod),
  .dram_op      (dram_op),
  .blk_mrs      (blk_mrs),
  .blk_other    (blk_other)
);

// File: tb/test_mrs_spacing_guard.sv
module test_mrs_spacing_guard;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int MR_W  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [2:0]       req_op = 3'd0;
  logic [MR_W-1:0]  req_mr = '0;
  logic             req_excp = 1'b0;
  logic [CNT_W-1:0] req_excp_cnt = '0;
  logic [CNT_W-1:0] cfg_tmrd = 8'd4;
  logic [CNT_W-1:0] cfg_tmod = 8'd7;
  logic [2:0]       dram_op;
  logic [MR_W-1:0]  dram_mr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [5:0] sb_q[$];

  int last_mrs = -1000;
  int need_mrd = 0;
  int need_mod = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mrs_spacing_guard #(.CNT_W(CNT_W), .MR_W(MR_W)) i_mrs_spacing_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mr(req_mr), .req_excp(req_excp),
    .req_excp_cnt(req_excp_cnt), .cfg_tmrd(cfg_tmrd), .cfg_tmod(cfg_tmod),
    .dram_op(dram_op), .dram_mr(dram_mr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every non-deselect on the bus must match the next queued item
  always @(posedge clk) begin
    #2;
    if (rst_n && dram_op != 3'd0) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 unexpected command on bus", int'(dram_op), 0);
      end else begin
        logic [5:0] e;
        e = sb_q.pop_front();
        check({dram_op, dram_mr} == e, "R2 bus command", int'({dram_op, dram_mr}), int'(e));
      end
    end
  end

  // driver: offer one command, hold it until taken, check the accept edge
  task automatic send(input logic [2:0] op, input logic [2:0] mr, input logic ex,
                      input logic [7:0] ov, input string req);
    int start;
    int need;
    int exp_e;
    int acc_e;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_mr = mr; req_excp = ex; req_excp_cnt = ov;
    start = cyc + 1;
    need  = (op == 3'd0) ? 0 : (op == 3'd1) ? need_mrd : need_mod;
    exp_e = (last_mrs + need > start) ? last_mrs + need : start;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
      if (cyc > 100000) break;
    end
    acc_e = cyc + 1;
    if (op != 3'd0) sb_q.push_back({op, mr});
    check(acc_e == exp_e, req, acc_e - start, exp_e - start);
    if (op == 3'd1) begin
      last_mrs = acc_e;
      need_mrd = ex ? int'(ov) : int'(cfg_tmrd);
      need_mod = ex ? int'(ov) : int'(cfg_tmod);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_op = 3'd0; req_excp = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(dram_op == 3'd0, "R1 bus idles at deselect", int'(dram_op), 0);
    req_op = 3'd2; req_valid = 1'b1; #1;
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    req_valid = 1'b0; req_op = 3'd0;
    send(3'd1, 3'd2, 1'b0, 8'd0, "R1 first MRS accepted at once");

    // R3 and R9: second MRS waits tMRD
    settle();
    send(3'd1, 3'd0, 1'b0, 8'd0, "R3 setup MRS");
    send(3'd1, 3'd3, 1'b0, 8'd0, "R3 MRS held for tMRD");

    // R4: other command waits tMOD
    settle();
    send(3'd1, 3'd4, 1'b0, 8'd0, "R4 setup MRS");
    send(3'd2, 3'd1, 1'b0, 8'd0, "R4 ACT held for tMOD");

    // R5: deselects pass freely and leave the window alone
    settle();
    send(3'd1, 3'd5, 1'b0, 8'd0, "R5 setup MRS");
    send(3'd0, 3'd0, 1'b0, 8'd0, "R5 deselect ready");
    send(3'd0, 3'd0, 1'b0, 8'd0, "R5 second deselect ready");
    send(3'd4, 3'd6, 1'b0, 8'd0, "R5 WR wait unchanged by deselects");

    // R6: override count
    settle();
    send(3'd1, 3'd6, 1'b1, 8'd2, "R6 setup short override MRS");
    send(3'd3, 3'd1, 1'b0, 8'd0, "R6 RD uses override 2");
    settle();
    send(3'd1, 3'd7, 1'b1, 8'd10, "R6 setup long override MRS");
    send(3'd1, 3'd1, 1'b0, 8'd0, "R6 MRS uses override 10");

    // R7: new MRS restarts both windows
    settle();
    @(negedge clk); cfg_tmrd = 8'd2; cfg_tmod = 8'd8;
    send(3'd1, 3'd0, 1'b0, 8'd0, "R7 first MRS");
    send(3'd1, 3'd1, 1'b0, 8'd0, "R7 second MRS inside tMOD");
    send(3'd5, 3'd2, 1'b0, 8'd0, "R7 PRE measured from second MRS");

    // R8: zero and one spacing allow back-to-back
    settle();
    @(negedge clk); cfg_tmrd = 8'd1; cfg_tmod = 8'd0;
    send(3'd1, 3'd3, 1'b0, 8'd0, "R8 MRS");
    send(3'd1, 3'd4, 1'b0, 8'd0, "R8 back-to-back MRS");
    send(3'd6, 3'd5, 1'b0, 8'd0, "R8 back-to-back REF");
    send(3'd7, 3'd6, 1'b0, 8'd0, "R8 back-to-back ZQC");

    settle();
    check(sb_q.size() == 0, "R2 all commands seen on bus", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule